// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a virtual address, given as a process ID, a virtual page number and a page offset, into a physical address. It uses an inverted table that holds one entry per physical frame. Each entry is either free or tagged with the process ID and virtual page that currently own that frame. The entry's index is the frame number. The lookup hashes the virtual page number to pick a home slot and compares the stored tag there with the request. On a mismatch it moves on through the table one slot per cycle. When a tag matches, the physical address is the frame index followed by the 12-bit offset. When every slot has been visited without a match, the lookup reports a miss.

A write port loads a tag into an entry or frees one, one entry per cycle. Software-side fault handling stays outside the block. A caller holds its request until the block accepts it. Acceptance is visible as the busy output rising. The caller then waits for a one-cycle response pulse.

Top module: `ipt_lookup`

## Requirements
- R1: While reset is applied, and after it is released, every entry is free and `lk_busy` and `rsp_valid` are low. A lookup issued into the empty table therefore misses.
- R2: The home slot of a lookup is the XOR fold of the virtual page number. Bit i of the page number is folded into bit (i mod log2(DEPTH)) of the slot index.
- R3: A request is accepted when `lk_req` is high, the block is idle and `wr_en` is low. If the home slot holds a live entry with an equal process ID and virtual page, `rsp_valid` pulses with `rsp_hit`=1 one cycle after acceptance. In that case `rsp_paddr` = {slot index, offset}.
- R4: On a mismatch the probe moves to slot (index+1) mod DEPTH, one slot per cycle, wrapping from the last slot to slot 0. A hit found n slots past the home slot responds n+1 cycles after acceptance.
- R5: When no entry matches, `rsp_valid` pulses DEPTH cycles after acceptance with `rsp_hit`=0 and `rsp_paddr`=0.
- R6: A freed entry (written with `wr_set`=0) never matches, even if the request carries its old tag.
- R7: A match requires equal process IDs. The same virtual page under another process ID misses.
- R8: Writes take priority over lookups. A request presented in a cycle with `wr_en` high is not accepted. During a probe, each cycle with `wr_en` high holds the probe at its current slot for one cycle, and the write is visible to the later compares.
- R9: `lk_busy` is high from acceptance until the response cycle. A request presented while busy is ignored and produces no response.
- R10: `rsp_valid` is a single-cycle pulse. `rsp_hit` and `rsp_paddr` are meaningful in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | IDX_W | Entry (frame) to write |
| wr_set | input | 1 | 1 loads the tag, 0 frees the entry |
| wr_pid | input | PID_W | Process ID to store |
| wr_vpn | input | VPN_W | Virtual page to store |
| lk_req | input | 1 | Lookup request, held until accepted |
| lk_pid | input | PID_W | Requesting process ID |
| lk_vpn | input | VPN_W | Virtual page number |
| lk_off | input | OFF_W | Page offset |
| lk_busy | output | 1 | A lookup is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response found a matching entry |
| rsp_paddr | output | IDX_W+OFF_W | Frame index followed by offset (0 on a miss) |

## Verification
The bench builds the block with its defaults: 8 frames, 8-bit process IDs, 52-bit virtual pages and 12-bit offsets. With only eight slots, a full miss walk takes eight cycles. Page numbers that collide in the 3-bit fold are easy to construct by flipping two bits three positions apart. The wrap from slot 7 to slot 0 is reached by a page whose fold is 7. These defaults also allow a write to be inserted into the middle of a probe, so the stall and late-visible entry can be timed exactly.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_SCAN = 1'b1
  } phase_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 52,
  parameter int IDX_W = 3
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] slot
);
  always_comb begin
    slot = '0;
    for (int i = 0; i < VPN_W; i++) begin
      slot[i % IDX_W] = slot[i % IDX_W] ^ vpn[i];
    end
  end
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int DEPTH = 8,
  parameter int PID_W = 8,
  parameter int VPN_W = 52,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_set,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_live,
  output logic [PID_W-1:0] rd_pid,
  output logic [VPN_W-1:0] rd_vpn
);
  logic [DEPTH-1:0] live_q;
  logic [PID_W-1:0] pid_q [DEPTH];
  logic [VPN_W-1:0] vpn_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[e] <= 1'b0;
      end else if (sel) begin
        live_q[e] <= wr_set;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && wr_set) begin
        pid_q[e] <= wr_pid;
        vpn_q[e] <= wr_vpn;
      end
    end
  end

  assign rd_live = live_q[rd_idx];
  assign rd_pid  = pid_q[rd_idx];
  assign rd_vpn  = vpn_q[rd_idx];
endmodule

// File: rtl/ipt_scan.sv
module ipt_scan
  import ipt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PID_W = 8,
  parameter int VPN_W = 52,
  parameter int OFF_W = 12,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PA_W = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             lk_req,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [OFF_W-1:0] lk_off,
  input  logic [IDX_W-1:0] home_idx,
  input  logic             rd_live,
  input  logic [PID_W-1:0] rd_pid,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_paddr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  phase_e           ph_q, ph_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             step_en;
  logic             cap_en;
  logic [PID_W-1:0] pid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             vld_d, hit_q, hit_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             vld_q;
  logic             match;

  assign match = rd_live && (rd_pid == pid_q) && (rd_vpn == vpn_q);

  always_comb begin
    ph_d    = ph_q;
    cur_d   = cur_q;
    cnt_d   = cnt_q;
    step_en = 1'b0;
    cap_en  = 1'b0;
    vld_d   = 1'b0;
    hit_d   = hit_q;
    pa_d    = pa_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (lk_req && !wr_en) begin
          ph_d    = PH_SCAN;
          cur_d   = home_idx;
          cnt_d   = '0;
          step_en = 1'b1;
          cap_en  = 1'b1;
        end
      end
      PH_SCAN: begin
        if (!wr_en) begin
          if (match) begin
            ph_d  = PH_IDLE;
            vld_d = 1'b1;
            hit_d = 1'b1;
            pa_d  = {cur_q, off_q};
          end else if (cnt_q == LAST) begin
            ph_d  = PH_IDLE;
            vld_d = 1'b1;
            hit_d = 1'b0;
            pa_d  = '0;
          end else begin
            cur_d   = (cur_q == LAST) ? '0 : cur_q + 1'b1;
            cnt_d   = cnt_q + 1'b1;
            step_en = 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      vld_q <= 1'b0;
      hit_q <= 1'b0;
      pa_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      vld_q <= vld_d;
      hit_q <= hit_d;
      pa_q  <= pa_d;
    end
  end

  always_ff @(posedge clk) begin
    if (step_en) begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
    if (cap_en) begin
      pid_q <= lk_pid;
      vpn_q <= lk_vpn;
      off_q <= lk_off;
    end
  end

  assign rd_idx    = cur_q;
  assign busy      = (ph_q == PH_SCAN);
  assign rsp_valid = vld_q;
  assign rsp_hit   = hit_q;
  assign rsp_paddr = pa_q;
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int DEPTH = 8,
  parameter int PID_W = 8,
  parameter int VPN_W = 52,
  parameter int OFF_W = 12,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PA_W = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_set,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             lk_req,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [OFF_W-1:0] lk_off,
  output logic             lk_busy,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_paddr
);
  logic [1:0]       rst_sync_q;
  logic             rst_q_n;
  logic [IDX_W-1:0] home_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_live;
  logic [PID_W-1:0] rd_pid;
  logic [VPN_W-1:0] rd_vpn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .vpn  (lk_vpn),
    .slot (home_idx)
  );

  ipt_table #(.DEPTH(DEPTH), .PID_W(PID_W), .VPN_W(VPN_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_set  (wr_set),
    .wr_pid  (wr_pid),
    .wr_vpn  (wr_vpn),
    .rd_idx  (rd_idx),
    .rd_live (rd_live),
    .rd_pid  (rd_pid),
    .rd_vpn  (rd_vpn)
  );

  ipt_scan #(.DEPTH(DEPTH), .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en     (wr_en),
    .lk_req    (lk_req),
    .lk_pid    (lk_pid),
    .lk_vpn    (lk_vpn),
    .lk_off    (lk_off),
    .home_idx  (home_idx),
    .rd_live   (rd_live),
    .rd_pid    (rd_pid),
    .rd_vpn    (rd_vpn),
    .rd_idx    (rd_idx),
    .busy      (lk_busy),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr)
  );
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int PA_W = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            lk_busy,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_paddr
);
  // R10
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  idle_at_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !lk_busy);

  // R8
  wr_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_busy && wr_en) |=> !lk_busy);

  // R8
  wr_stalls_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_busy && wr_en) |=> (lk_busy && !rsp_valid));

  // R5
  miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));
endmodule

bind ipt_lookup ipt_lookup_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .wr_en     (wr_en),
  .lk_busy   (lk_busy),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_paddr (rsp_paddr)
);

// File: tb/ipt_lookup_test.sv
module ipt_lookup_test;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam int PID_W = 8;
  localparam int VPN_W = 52;
  localparam int OFF_W = 12;
  localparam int PA_W  = IDX_W + OFF_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en, wr_set;
  logic [IDX_W-1:0] wr_idx;
  logic [PID_W-1:0] wr_pid, lk_pid;
  logic [VPN_W-1:0] wr_vpn, lk_vpn;
  logic             lk_req;
  logic [OFF_W-1:0] lk_off;
  logic             lk_busy, rsp_valid, rsp_hit;
  logic [PA_W-1:0]  rsp_paddr;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ipt_lookup uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_set(wr_set), .wr_pid(wr_pid), .wr_vpn(wr_vpn),
    .lk_req(lk_req), .lk_pid(lk_pid), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .lk_busy(lk_busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr)
  );

  function automatic logic [IDX_W-1:0] fold(input logic [VPN_W-1:0] v);
    logic [IDX_W-1:0] h = '0;
    for (int i = 0; i < VPN_W; i++) h[i % IDX_W] ^= v[i];
    return h;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_entry(input logic [IDX_W-1:0] idx, input logic set,
                             input logic [PID_W-1:0] pid, input logic [VPN_W-1:0] vpn);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_set = set; wr_pid = pid; wr_vpn = vpn;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issues one lookup; returns response and cycles from acceptance edge to response.
  task automatic lookup(input string req, input logic [PID_W-1:0] pid,
                        input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                        output logic hit, output logic [PA_W-1:0] pa, output int cyc);
    @(negedge clk);
    lk_req = 1'b1; lk_pid = pid; lk_vpn = vpn; lk_off = off;
    @(negedge clk);
    lk_req = 1'b0;
    cyc = 0;
    check({req, " R9 busy after accept"}, lk_busy, 1'b1);
    while (!rsp_valid && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    hit = rsp_hit; pa = rsp_paddr;
    @(negedge clk);
    check({req, " R10 single pulse"}, rsp_valid, 1'b0);
  endtask

  logic [VPN_W-1:0] va, vb, vc, vd;
  logic             h;
  logic [PA_W-1:0]  pa;
  int               cyc;

  task automatic t_reset;
    check("R1 busy in reset", lk_busy, 1'b0);
    check("R1 rsp_valid in reset", rsp_valid, 1'b0);
    lookup("R1", 8'd1, va, 12'h000, h, pa, cyc);
    check("R1 empty table misses", h, 1'b0);
    check("R5 miss latency", cyc, DEPTH);
    check("R5 miss address zero", pa, '0);
  endtask

  task automatic t_home_hit;
    write_entry(fold(va), 1'b1, 8'd1, va);
    lookup("R3", 8'd1, va, 12'hABC, h, pa, cyc);
    check("R3 hit", h, 1'b1);
    check("R3 one cycle", cyc, 1);
    check("R2 R3 paddr", pa, {fold(va), 12'hABC});
  endtask

  task automatic t_probe;
    write_entry(fold(vb) + 3'd1, 1'b1, 8'd1, vb);
    lookup("R4", 8'd1, vb, 12'h123, h, pa, cyc);
    check("R4 collide hit", h, 1'b1);
    check("R4 collide latency", cyc, 2);
    check("R4 collide paddr", pa, {fold(vb) + 3'd1, 12'h123});
    write_entry(3'd0, 1'b1, 8'd1, vc);
    lookup("R4 wrap", 8'd1, vc, 12'hFFF, h, pa, cyc);
    check("R4 wrap hit", h, 1'b1);
    check("R4 wrap latency", cyc, 2);
    check("R4 wrap paddr", pa, {3'd0, 12'hFFF});
  endtask

  task automatic t_pid;
    lookup("R7", 8'd2, va, 12'h010, h, pa, cyc);
    check("R7 other pid misses", h, 1'b0);
    check("R7 miss latency", cyc, DEPTH);
  endtask

  task automatic t_free;
    write_entry(fold(va), 1'b0, 8'd1, va);
    lookup("R6", 8'd1, va, 12'h010, h, pa, cyc);
    check("R6 freed entry misses", h, 1'b0);
  endtask

  task automatic t_write_prio;
    int c;
    // request and write in the same cycle: request must not start
    @(negedge clk);
    lk_req = 1'b1; lk_pid = 8'd1; lk_vpn = vc; lk_off = 12'h0;
    wr_en = 1'b1; wr_idx = 3'd6; wr_set = 1'b0; wr_pid = '0; wr_vpn = '0;
    @(negedge clk);
    lk_req = 1'b0; wr_en = 1'b0;
    check("R8 not accepted with write", lk_busy, 1'b0);
    c = 0;
    repeat (DEPTH + 2) begin
      @(negedge clk);
      if (rsp_valid) c++;
    end
    check("R8 no response", c, 0);
    // write during probe stalls one cycle and becomes visible
    @(negedge clk);
    lk_req = 1'b1; lk_pid = 8'd1; lk_vpn = vd; lk_off = 12'h5A5;
    @(negedge clk);
    lk_req = 1'b0;
    wr_en = 1'b1; wr_idx = fold(vd) + 3'd2; wr_set = 1'b1; wr_pid = 8'd1; wr_vpn = vd;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 stalled probe busy", lk_busy, 1'b1);
    c = 1;
    while (!rsp_valid && c < 40) begin
      @(negedge clk);
      c++;
    end
    check("R8 stall latency", c, 4);
    check("R8 late entry hit", rsp_hit, 1'b1);
    check("R8 late entry paddr", rsp_paddr, {fold(vd) + 3'd2, 12'h5A5});
  endtask

  task automatic t_busy_ignore;
    int c;
    @(negedge clk);
    lk_req = 1'b1; lk_pid = 8'd9; lk_vpn = va; lk_off = 12'h0;
    @(negedge clk);
    lk_pid = 8'd1; lk_vpn = vc; lk_off = 12'h777;
    @(negedge clk);
    lk_req = 1'b0;
    check("R9 still busy", lk_busy, 1'b1);
    c = 0;
    repeat (3 * DEPTH) begin
      @(negedge clk);
      if (rsp_valid) begin
        c++;
        check("R9 only first request answered", rsp_hit, 1'b0);
      end
    end
    check("R9 one response", c, 1);
    check("R9 idle after", lk_busy, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    va = 52'h12345;          // fold 1
    vb = va ^ 52'h9;         // collides with va
    vc = 52'h7;              // fold 7, wraps to slot 0
    vd = 52'h40;             // fold 1
    rst_n = 1'b0; wr_en = 1'b0; wr_set = 1'b0; wr_idx = '0; wr_pid = '0; wr_vpn = '0;
    lk_req = 1'b0; lk_pid = '0; lk_vpn = '0; lk_off = '0;
    repeat (4) @(negedge clk);
    check("R1 busy low in reset", lk_busy, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_home_hit();
    t_probe();
    t_pid();
    t_free();
    t_write_prio();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule